// File: doc/BRIEF.md
# Flying-Capacitor Staircase Switching Sequencer

This block produces the four cell commands for one phase limb of a four-cell, five-level flying-capacitor inverter. It runs fundamental-frequency staircase modulation. A phase accumulator advances by a programmable increment on every enabled clock. Two programmable switching angles decide where the output steps between its five levels. Each cell bit drives one complementary switch pair. Bit 3 is the pair nearest the DC link and bit 0 the pair nearest the load. A 1 means that pair's upper switch conducts.

Several switch words give the same output level. To spread the flying-capacitor charge evenly, the block uses a different redundant word for each level in each of four consecutive fundamental cycles. It then repeats the rotation. Every level step flips exactly one cell bit, so only one pair commutates at a time and each pair switches once on and once off per cycle. The angle values come from an external table and are taken in only at the cycle boundary.

The accumulator's zero point is placed at the centre of the negative plateau, 270 degrees of the fundamental. Every cycle boundary, where the pattern rotates and new angles are applied, therefore falls where all four sequences share the word 0000.

Top module: `fc_stair_seq`

## Requirements
- R1: Reset clears the accumulator and pattern index, loads the default angles, and drives state_o to 0000 and level_o to 0. After reset the first sequence taken is 0000, 0001, 0011, 0111, 1111.
- R2: level_o equals the number of 1 bits in state_o. Codes 0 to 4 mean levels -1, -0.5, 0, +0.5 and +1.
- R3: The accumulator value P is compared with the held angles a1 and a2, with Q a quarter turn. The level code is 0 below Q-a2, 1 below Q-a1, 2 below Q+a1, 3 below Q+a2, 4 below 3Q-a2, 3 below 3Q-a1, 2 below 3Q+a1, 1 below 3Q+a2, and 0 above that. An enabled edge stores in state_o/level_o the result for the accumulator value held before that edge, then adds phase_inc to the accumulator modulo a full turn.
- R4: With pattern index p, a level code of k sets bits (p+i) mod 4 for i = 0 to k-1. The four cycles therefore use 0,1,3,7,F / 0,2,6,E,F / 0,4,C,D,F / 0,8,9,B,F. The first -0.5 word of each cycle is the previous cycle's word rotated left by one.
- R5: The pattern index advances by one, modulo 4, on each enabled edge where the accumulator carries out of its top bit.
- R6: ang1_in and ang2_in are sampled only on that carry edge. Reset restores defaults equal to 26.13 and 60.97 degrees as fractions of a turn (4757 and 11099 for a 16-bit phase).
- R7: While en is low, the accumulator, the pattern index, the angles and both outputs hold.
- R8: For 0 < a1 < a2 < Q, and phase_inc smaller than every gap between adjacent thresholds, each output update changes at most one bit of state_o.
- R9: Over each complete fundamental cycle every cell bit toggles exactly twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance enable; low holds all state |
| phase_inc | input | PHASE_W | Accumulator increment per enabled clock |
| ang1_in | input | PHASE_W | First switching angle, fraction of a turn |
| ang2_in | input | PHASE_W | Second switching angle, fraction of a turn |
| state_o | output | 4 | Cell commands, bit 3 nearest the DC link |
| level_o | output | 3 | Level code 0..4 for -1..+1 |

## Verification
The hardest situation to reach is a new angle set arriving in the middle of a fundamental cycle. The current cycle must finish on the old thresholds, and the new ones must take hold exactly at the wrap. The bench changes the angle inputs on the +1 plateau and keeps an exact cycle-by-cycle model of the staircase. A later reset is issued while the non-default angle inputs are still present, which shows that the defaults come back and that the rotation restarts at sequence 0,1,3,7,F.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int NUM_CELLS = 4;
  localparam int LVL_W     = 3;
  typedef logic [NUM_CELLS-1:0] cell_word_t;

  // Set k cells starting at the rotated origin of pattern p.
  function automatic cell_word_t fill_cells(input logic [1:0] pat,
                                            input logic [LVL_W-1:0] cnt);
    cell_word_t w;
    logic [1:0] idx;
    w = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      idx = pat + 2'(i);
      if (i < int'(cnt)) w[idx] = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/fc_phase_gen.sv
module fc_phase_gen #(
  parameter int W = 16,
  parameter logic [W-1:0] A1_INIT = '0,
  parameter logic [W-1:0] A2_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] a1_in,
  input  logic [W-1:0] a2_in,
  output logic [W-1:0] acc_o,
  output logic         wrap_o,
  output logic [1:0]   pat_o,
  output logic [W-1:0] a1_o,
  output logic [W-1:0] a2_o
);
  logic [W:0] sum;

  assign sum    = {1'b0, acc_o} + {1'b0, inc};
  assign wrap_o = sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_o <= '0;
      pat_o <= '0;
      a1_o  <= A1_INIT;
      a2_o  <= A2_INIT;
    end else if (en) begin
      acc_o <= sum[W-1:0];
      if (wrap_o) begin
        pat_o <= pat_o + 2'd1;
        a1_o  <= a1_in;
        a2_o  <= a2_in;
      end
    end
  end
endmodule

// File: rtl/fc_level_dec.sv
module fc_level_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] a2,
  output logic [2:0]   lvl
);
  localparam int NTHR = 8;
  localparam logic [W-1:0] QTR  = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] TQTR = {2'b11, {(W-2){1'b0}}};

  logic [NTHR-1:0] pass;
  logic [3:0]      n;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    localparam logic [W-1:0] BASE = (g < 4) ? QTR : TQTR;
    localparam bit USE_A2 = ((g % 4) == 0) || ((g % 4) == 3);
    localparam bit SUB    = (g % 4) < 2;
    logic [W-1:0] ang;
    logic [W-1:0] thr;
    assign ang     = USE_A2 ? a2 : a1;
    assign thr     = SUB ? (BASE - ang) : (BASE + ang);
    assign pass[g] = acc >= thr;
  end

  always_comb begin
    n = '0;
    for (int i = 0; i < NTHR; i++) n = n + 4'(pass[i]);
    lvl = (n <= 4'd4) ? n[2:0] : 3'(4'd8 - n);
  end
endmodule

// File: rtl/fc_cell_pick.sv
module fc_cell_pick
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pat,
  input  logic [2:0] lvl,
  output cell_word_t state_o,
  output logic [2:0] level_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o <= '0;
      level_o <= '0;
    end else if (en) begin
      state_o <= fill_cells(pat, lvl);
      level_o <= lvl;
    end
  end
endmodule

// File: rtl/fc_stair_seq.sv
module fc_stair_seq #(
  parameter int  PHASE_W    = 16,
  parameter real ALPHA1_DEG = 26.13,
  parameter real ALPHA2_DEG = 60.97
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [PHASE_W-1:0] ang1_in,
  input  logic [PHASE_W-1:0] ang2_in,
  output logic [3:0]         state_o,
  output logic [2:0]         level_o
);
  localparam longint A1_CNT = longint'(ALPHA1_DEG * (2.0 ** PHASE_W) / 360.0);
  localparam longint A2_CNT = longint'(ALPHA2_DEG * (2.0 ** PHASE_W) / 360.0);
  localparam logic [PHASE_W-1:0] A1_DEF = A1_CNT[PHASE_W-1:0];
  localparam logic [PHASE_W-1:0] A2_DEF = A2_CNT[PHASE_W-1:0];

  logic [PHASE_W-1:0] acc_q;
  logic               acc_wrap;
  logic [1:0]         pat_idx;
  logic [PHASE_W-1:0] ang1_q;
  logic [PHASE_W-1:0] ang2_q;
  logic [2:0]         lvl_c;

  fc_phase_gen #(.W(PHASE_W), .A1_INIT(A1_DEF), .A2_INIT(A2_DEF)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .inc(phase_inc),
    .a1_in(ang1_in), .a2_in(ang2_in),
    .acc_o(acc_q), .wrap_o(acc_wrap), .pat_o(pat_idx),
    .a1_o(ang1_q), .a2_o(ang2_q)
  );

  fc_level_dec #(.W(PHASE_W)) u_level (
    .acc(acc_q), .a1(ang1_q), .a2(ang2_q), .lvl(lvl_c)
  );

  fc_cell_pick u_pick (
    .clk(clk), .rst_n(rst_n), .en(en), .pat(pat_idx), .lvl(lvl_c),
    .state_o(state_o), .level_o(level_o)
  );
endmodule

// File: rtl/fc_stair_chk.sv
module fc_stair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         wrap,
  input logic [1:0]   pat,
  input logic [W-1:0] a1,
  input logic [W-1:0] a2,
  input logic [3:0]   state,
  input logic [2:0]   level
);
  // R8
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state ^ $past(state)) <= 1);

  // R2
  level_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) == $countones(state));

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(state) && $stable(level) && $stable(pat)));

  // R5
  pattern_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap) |=> (pat == $past(pat) + 2'd1));

  // R6
  angle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && wrap) |=> ($stable(a1) && $stable(a2)));
endmodule

bind fc_stair_seq fc_stair_chk #(.W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wrap(acc_wrap), .pat(pat_idx),
  .a1(ang1_q), .a2(ang2_q), .state(state_o), .level(level_o)
);

// File: tb/sim_fc_stair_seq.sv
module sim_fc_stair_seq;
  localparam int CLK_P = 10;
  localparam int Q  = 16384;
  localparam int TQ = 49152;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] phase_inc = 16'd1024;
  logic [15:0] ang1_in = 16'd4757;
  logic [15:0] ang2_in = 16'd11099;
  logic [3:0]  state_o;
  logic [2:0]  level_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_acc, m_pat, m_a1, m_a2;
  logic [3:0] exp_state, prev_out, last_rec;
  int exp_lvl;
  bit have_rec;
  int tog [4];

  always #(CLK_P/2) clk = ~clk;

  fc_stair_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc),
    .ang1_in(ang1_in), .ang2_in(ang2_in), .state_o(state_o), .level_o(level_o)
  );

  function automatic int tb_level(input int a, input int x1, input int x2);
    if (a < Q - x2) return 0;
    else if (a < Q - x1) return 1;
    else if (a < Q + x1) return 2;
    else if (a < Q + x2) return 3;
    else if (a < TQ - x2) return 4;
    else if (a < TQ - x1) return 3;
    else if (a < TQ + x1) return 2;
    else if (a < TQ + x2) return 1;
    else return 0;
  endfunction

  function automatic logic [3:0] tb_state(input int p, input int k);
    case (p)
      0: case (k) 0: return 4'h0; 1: return 4'h1; 2: return 4'h3; 3: return 4'h7; default: return 4'hF; endcase
      1: case (k) 0: return 4'h0; 1: return 4'h2; 2: return 4'h6; 3: return 4'hE; default: return 4'hF; endcase
      2: case (k) 0: return 4'h0; 1: return 4'h4; 2: return 4'hC; 3: return 4'hD; default: return 4'hF; endcase
      default: case (k) 0: return 4'h0; 1: return 4'h8; 2: return 4'h9; 3: return 4'hB; default: return 4'hF; endcase
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_pat = 0; m_a1 = 4757; m_a2 = 11099;
    exp_state = 4'h0; exp_lvl = 0; prev_out = 4'h0; have_rec = 0;
  endtask

  task automatic step();
    logic en_c;
    int inc_c, a1_c, a2_c, sum;
    en_c = en; inc_c = int'(phase_inc); a1_c = int'(ang1_in); a2_c = int'(ang2_in);
    @(posedge clk); #1;
    if (en_c) begin
      exp_lvl = tb_level(m_acc, m_a1, m_a2);
      exp_state = tb_state(m_pat, exp_lvl);
      sum = m_acc + inc_c;
      m_acc = sum % 65536;
      if (sum >= 65536) begin
        m_pat = (m_pat + 1) % 4; m_a1 = a1_c; m_a2 = a2_c;
      end
    end
    chk(state_o == exp_state, "R3/R4/R5/R6 state", int'(state_o), int'(exp_state));
    chk(int'(level_o) == $countones(state_o), "R2 level vs ones", int'(level_o), $countones(state_o));
    chk($countones(state_o ^ prev_out) <= 1, "R8 single bit flip", int'(state_o), int'(prev_out));
    for (int b = 0; b < 4; b++) if (state_o[b] != prev_out[b]) tog[b]++;
    if ($countones(prev_out) == 0 && $countones(state_o) == 1) begin
      if (have_rec)
        chk(state_o == {last_rec[2:0], last_rec[3]}, "R4 rotation", int'(state_o),
            int'({last_rec[2:0], last_rec[3]}));
      else
        chk(state_o == 4'h1, "R1 first sequence after reset", int'(state_o), 1);
      last_rec = state_o; have_rec = 1;
    end
    prev_out = state_o;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0;
    @(posedge clk); #1;
    model_reset();
    chk(state_o == 4'h0, "R1 reset state", int'(state_o), 0);
    chk(level_o == 3'd0, "R1 reset level", int'(level_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_default_run();
    phase_inc = 16'd1024; en = 1'b1;
    for (int b = 0; b < 4; b++) tog[b] = 0;
    repeat (260) step();
    for (int b = 0; b < 4; b++) chk(tog[b] == 8, "R9 toggles per bit over four cycles", tog[b], 8);
  endtask

  task automatic t_hold();
    logic [3:0] saved;
    logic [2:0] saved_l;
    repeat (20) step();
    en = 1'b0;
    saved = state_o; saved_l = level_o;
    repeat (20) step();
    chk(state_o == saved, "R7 state held", int'(state_o), int'(saved));
    chk(level_o == saved_l, "R7 level held", int'(level_o), int'(saved_l));
    en = 1'b1;
    repeat (60) step();
  endtask

  task automatic t_angles();
    while (tb_level(m_acc, m_a1, m_a2) != 4) step();
    ang1_in = 16'd2000; ang2_in = 16'd12000;
    repeat (200) step();
    chk(m_a1 == 2000, "R6 new angle taken at wrap", m_a1, 2000);
  endtask

  task automatic t_odd_inc();
    phase_inc = 16'd997;
    repeat (530) step();
  endtask

  task automatic t_reset_mid();
    repeat (30) step();
    t_reset();
    en = 1'b1; phase_inc = 16'd1024;
    repeat (140) step();
    chk(have_rec == 1, "R1 sequence observed after reset", int'(have_rec), 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_default_run();
    t_hold();
    t_angles();
    t_odd_inc();
    t_reset_mid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule